// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block sits at the issue stage of a six-thread, in-order, simultaneously multithreaded pipeline. Every thread owns an instruction queue. The block sees, for each queue, an empty flag and the first few head entries. Each head entry carries a valid bit, a grouping flag, an already resolved predicate value and the instruction word. Each cycle the block picks one thread under a policy chosen at run time. From that thread's queue head it forms an issue group of up to four instructions. It then returns a per-slot valid mask, the instruction words and a pop count for each queue.

The grouping flags are set ahead of time by the code generator. A flag of 0 means the next instruction may issue alongside this one. A flag of 1 closes the group after this instruction. An instruction whose predicate is false still leaves its queue, but its slot is not marked valid, so nothing downstream executes it.

Threads are numbered 0 to 5. Thread 0 is the first thread and thread 5 is the last. All outputs are combinational from the inputs and two small state registers: the last granted thread and the alternation phase. Both registers advance at the clock edge that ends a cycle in which a grant was made.

Top module: `smt_issue_sel`

## Requirements
- R1: A thread is eligible only when its `q_empty` bit is 0. An ineligible thread is passed over within the same cycle, so a grant goes to an eligible thread whenever one exists.
- R2: With `mode_sel` = 2'b00 (rotating), the grant goes to the first eligible thread found by searching upward from the thread after the last granted one, wrapping from thread 5 to thread 0. After reset the last granted thread is 5, so thread 0 is searched first.
- R3: With `mode_sel` = 2'b01 (fixed), the grant goes to the lowest-numbered eligible thread.
- R4: With `mode_sel` = 2'b10 (alternating), the search direction flips after every grant made in this mode. In the low phase the search runs upward from thread 0. In the high phase it runs downward from thread 5. The phase is low after reset.
- R5: `mode_sel` = 2'b11 behaves exactly like the rotating mode.
- R6: The last-granted register takes the granted thread after every grant, in any mode. The alternation phase changes only on grants made in mode 2'b10. When no grant is made, neither register changes.
- R7: When every queue is empty, `grant_valid` is 0, `slot_valid` is 0 and every pop count is 0.
- R8: The group starts at head entry 0 of the granted thread and extends one entry at a time. An entry whose grouping flag is 0 lets the next entry join. An entry whose flag is 1 is the last member of the group.
- R9: A group never exceeds 4 slots, even when all its flags are 0. A group also ends before the first head entry whose valid bit is 0.
- R10: The granted thread's pop count equals its group length. Every other thread's pop count is 0. The pop count of thread t is the 3-bit field `pop_cnt[3t+2:3t]`.
- R11: `slot_valid[i]` is 1 exactly when slot i is inside the group and the predicate of head entry i is 1. An entry with a false predicate is still counted in the pop count.
- R12: Slot i of `issue_insn` (bits 32i+31:32i) carries head entry i of the granted thread. Head entry i of thread t sits at bit 4t+i of `head_vld`, `head_par` and `head_pred`, and at bits 32(4t+i)+31 down to 32(4t+i) of `head_insn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Policy: 00 rotating, 01 fixed, 10 alternating, 11 rotating |
| q_empty | input | 6 | Per-thread queue empty flag |
| head_vld | input | 24 | Presence of head entry i of thread t, bit 4t+i |
| head_par | input | 24 | Grouping flag of each head entry (1 closes the group) |
| head_pred | input | 24 | Resolved predicate of each head entry |
| head_insn | input | 768 | Instruction word of each head entry, 32 bits each |
| grant_valid | output | 1 | A thread was granted this cycle |
| grant_tid | output | 3 | Granted thread number |
| slot_valid | output | 4 | Per-slot issue enable |
| issue_insn | output | 128 | Instruction words of the four slots |
| pop_cnt | output | 18 | Entries to pop per thread, 3 bits each |

## Verification
The checker watches several rules on every cycle. A grant never goes to an empty queue. An all-empty cycle produces no grant and no pops. Fixed mode never skips a lower-numbered eligible thread. Only the granted thread pops, and never more than four entries. No valid slot lies outside the group. The checker also confirms that the last-granted register and the alternation phase hold over idle cycles, that the register records each grant, and that the phase flips on each grant in alternating mode. The exact rotating and alternating grant sequences, the point where a group closes on a flag, a cap or a missing entry, the predicate masking, and the routing of instruction words are shown only by the bench's scenarios, which compare each cycle against an independent model.

// File: rtl/smt_issue_pkg.sv
package smt_issue_pkg;

  typedef enum logic [1:0] {
    POL_ROTATE = 2'b00,
    POL_FIXED  = 2'b01,
    POL_ALTER  = 2'b10,
    POL_SPARE  = 2'b11
  } policy_e;

  // First set bit of req[n-1:0] searching upward from start, wrapping.
  function automatic int pick_up(input logic [31:0] req, input int n, input int start);
    int idx;
    int res;
    bit found;
    res = 0;
    found = 1'b0;
    for (int k = 0; k < 32; k++) begin
      if (k < n) begin
        idx = start + k;
        if (idx >= n) idx = idx - n;
        if (!found && req[idx]) begin
          res = idx;
          found = 1'b1;
        end
      end
    end
    return res;
  endfunction

  // First set bit of req[n-1:0] searching downward from n-1.
  function automatic int pick_down(input logic [31:0] req, input int n);
    int res;
    bit found;
    res = 0;
    found = 1'b0;
    for (int k = 31; k >= 0; k--) begin
      if (k < n && !found && req[k]) begin
        res = k;
        found = 1'b1;
      end
    end
    return res;
  endfunction

  // Length of the issue group formed from head entries.
  function automatic int group_len(input logic [31:0] vld, input logic [31:0] par, input int cap);
    int len;
    bit stop;
    len = 0;
    stop = 1'b0;
    for (int k = 0; k < 32; k++) begin
      if (k < cap && !stop) begin
        if (vld[k]) begin
          len = k + 1;
          if (par[k]) stop = 1'b1;
        end else begin
          stop = 1'b1;
        end
      end
    end
    return len;
  endfunction

endpackage

// File: rtl/smt_thr_arbiter.sv
module smt_thr_arbiter
  import smt_issue_pkg::*;
#(
  parameter int NUM_THR = 6,
  parameter int TID_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  policy_e            mode,
  input  logic [NUM_THR-1:0] req,
  output logic               gnt_vld,
  output logic [TID_W-1:0]   gnt_tid,
  output logic [TID_W-1:0]   rr_last,
  output logic               alt_hi
);

  localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THR - 1);

  logic [TID_W-1:0] rr_start;

  always_comb begin
    rr_start = (rr_last >= LAST_TID) ? '0 : rr_last + 1'b1;
    gnt_vld  = |req;
    case (mode)
      POL_FIXED: gnt_tid = TID_W'(pick_up(32'(req), NUM_THR, 0));
      POL_ALTER: gnt_tid = alt_hi ? TID_W'(pick_down(32'(req), NUM_THR))
                                  : TID_W'(pick_up(32'(req), NUM_THR, 0));
      default:   gnt_tid = TID_W'(pick_up(32'(req), NUM_THR, int'(rr_start)));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_last <= LAST_TID;
      alt_hi  <= 1'b0;
    end else if (gnt_vld) begin
      rr_last <= gnt_tid;
      if (mode == POL_ALTER) alt_hi <= ~alt_hi;
    end
  end

endmodule

// File: rtl/smt_group_former.sv
module smt_group_former
  import smt_issue_pkg::*;
#(
  parameter int NUM_THR = 6,
  parameter int SLOTS   = 4,
  parameter int INSN_W  = 32,
  parameter int TID_W   = 3,
  parameter int CNT_W   = 3
) (
  input  logic                              sel_vld,
  input  logic [TID_W-1:0]                  sel_tid,
  input  logic [NUM_THR*SLOTS-1:0]          head_vld,
  input  logic [NUM_THR*SLOTS-1:0]          head_par,
  input  logic [NUM_THR*SLOTS-1:0]          head_pred,
  input  logic [NUM_THR*SLOTS*INSN_W-1:0]   head_insn,
  output logic [SLOTS-1:0]                  slot_valid,
  output logic [SLOTS*INSN_W-1:0]           issue_insn,
  output logic [NUM_THR*CNT_W-1:0]          pop_cnt
);

  localparam int ROW_W = SLOTS * INSN_W;

  logic [CNT_W-1:0] len_t [NUM_THR];
  logic [CNT_W-1:0] grp_len;
  logic [SLOTS-1:0] sel_pred;

  // Each thread's group length is computed in parallel, then selected.
  for (genvar t = 0; t < NUM_THR; t++) begin : g_len
    assign len_t[t] = CNT_W'(group_len(32'(head_vld[t*SLOTS +: SLOTS]),
                                       32'(head_par[t*SLOTS +: SLOTS]), SLOTS));
  end

  always_comb begin
    grp_len    = '0;
    sel_pred   = '0;
    issue_insn = '0;
    pop_cnt    = '0;
    for (int t = 0; t < NUM_THR; t++) begin
      if (sel_vld && sel_tid == TID_W'(t)) begin
        grp_len    = len_t[t];
        sel_pred   = head_pred[t*SLOTS +: SLOTS];
        issue_insn = head_insn[t*ROW_W +: ROW_W];
        pop_cnt[t*CNT_W +: CNT_W] = len_t[t];
      end
    end
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign slot_valid[i] = (CNT_W'(i) < grp_len) && sel_pred[i];
  end

endmodule

// File: rtl/smt_issue_sel.sv
module smt_issue_sel
  import smt_issue_pkg::*;
#(
  parameter int NUM_THR = 6,
  parameter int SLOTS   = 4,
  parameter int INSN_W  = 32,
  parameter int TID_W   = $clog2(NUM_THR),
  parameter int CNT_W   = $clog2(SLOTS + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [1:0]                      mode_sel,
  input  logic [NUM_THR-1:0]              q_empty,
  input  logic [NUM_THR*SLOTS-1:0]        head_vld,
  input  logic [NUM_THR*SLOTS-1:0]        head_par,
  input  logic [NUM_THR*SLOTS-1:0]        head_pred,
  input  logic [NUM_THR*SLOTS*INSN_W-1:0] head_insn,
  output logic                            grant_valid,
  output logic [TID_W-1:0]                grant_tid,
  output logic [SLOTS-1:0]                slot_valid,
  output logic [SLOTS*INSN_W-1:0]         issue_insn,
  output logic [NUM_THR*CNT_W-1:0]        pop_cnt
);

  // Named internal state brought out for the checker.
  logic [NUM_THR-1:0] thr_req;
  logic [TID_W-1:0]   rr_last;
  logic               alt_hi;

  assign thr_req = ~q_empty;

  smt_thr_arbiter #(
    .NUM_THR (NUM_THR),
    .TID_W   (TID_W)
  ) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (policy_e'(mode_sel)),
    .req     (thr_req),
    .gnt_vld (grant_valid),
    .gnt_tid (grant_tid),
    .rr_last (rr_last),
    .alt_hi  (alt_hi)
  );

  smt_group_former #(
    .NUM_THR (NUM_THR),
    .SLOTS   (SLOTS),
    .INSN_W  (INSN_W),
    .TID_W   (TID_W),
    .CNT_W   (CNT_W)
  ) u_grp (
    .sel_vld    (grant_valid),
    .sel_tid    (grant_tid),
    .head_vld   (head_vld),
    .head_par   (head_par),
    .head_pred  (head_pred),
    .head_insn  (head_insn),
    .slot_valid (slot_valid),
    .issue_insn (issue_insn),
    .pop_cnt    (pop_cnt)
  );

endmodule

// File: rtl/smt_issue_sel_chk.sv
module smt_issue_sel_chk #(
  parameter int NUM_THR = 6,
  parameter int SLOTS   = 4,
  parameter int TID_W   = 3,
  parameter int CNT_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               mode_sel,
  input logic [NUM_THR-1:0]       q_empty,
  input logic                     grant_valid,
  input logic [TID_W-1:0]         grant_tid,
  input logic [SLOTS-1:0]         slot_valid,
  input logic [NUM_THR*CNT_W-1:0] pop_cnt,
  input logic [TID_W-1:0]         rr_last,
  input logic                     alt_hi
);

  logic [CNT_W-1:0]   gpop;
  logic [31:0]        pop_sum;
  logic [NUM_THR-1:0] below;
  logic               gsel_empty;
  logic [SLOTS-1:0]   in_grp;

  always_comb begin
    gpop       = '0;
    pop_sum    = '0;
    gsel_empty = 1'b0;
    for (int t = 0; t < NUM_THR; t++) begin
      pop_sum  = pop_sum + 32'(pop_cnt[t*CNT_W +: CNT_W]);
      below[t] = (TID_W'(t) < grant_tid);
      if (grant_tid == TID_W'(t)) begin
        gpop       = pop_cnt[t*CNT_W +: CNT_W];
        gsel_empty = q_empty[t];
      end
    end
    for (int i = 0; i < SLOTS; i++) in_grp[i] = (CNT_W'(i) < gpop);
  end

  // R1
  granted_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !gsel_empty);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&q_empty) |-> (!grant_valid && slot_valid == '0 && pop_sum == 32'd0));

  // R3
  fixed_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && grant_valid) |-> ((~q_empty & below) == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |=> ($stable(rr_last) && $stable(alt_hi)));

  // R2
  last_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |=> (rr_last == $past(grant_tid)));

  // R4
  alt_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10 && grant_valid) |=> (alt_hi != $past(alt_hi)));

  // R10
  single_popper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_sum == 32'(gpop));

  // R9
  group_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(gpop) <= SLOTS);

  // R11
  slot_in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid & ~in_grp) == '0);

endmodule

bind smt_issue_sel smt_issue_sel_chk #(
  .NUM_THR (NUM_THR),
  .SLOTS   (SLOTS),
  .TID_W   (TID_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_sel    (mode_sel),
  .q_empty     (q_empty),
  .grant_valid (grant_valid),
  .grant_tid   (grant_tid),
  .slot_valid  (slot_valid),
  .pop_cnt     (pop_cnt),
  .rr_last     (rr_last),
  .alt_hi      (alt_hi)
);

// File: tb/sim_smt_issue_sel.sv
module sim_smt_issue_sel;
  localparam int NT = 6;
  localparam int SL = 4;
  localparam int IW = 32;
  localparam int TW = 3;
  localparam int CW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic [1:0]       mode_sel;
  logic [NT-1:0]    q_empty;
  logic [NT*SL-1:0] head_vld, head_par, head_pred;
  logic [NT*SL*IW-1:0] head_insn;
  logic             grant_valid;
  logic [TW-1:0]    grant_tid;
  logic [SL-1:0]    slot_valid;
  logic [SL*IW-1:0] issue_insn;
  logic [NT*CW-1:0] pop_cnt;

  smt_issue_sel u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .q_empty(q_empty),
    .head_vld(head_vld), .head_par(head_par), .head_pred(head_pred),
    .head_insn(head_insn), .grant_valid(grant_valid), .grant_tid(grant_tid),
    .slot_valid(slot_valid), .issue_insn(issue_insn), .pop_cnt(pop_cnt)
  );

  typedef struct {
    string            tag;
    logic             gv;
    logic [TW-1:0]    tid;
    logic [SL-1:0]    sv;
    logic [NT*CW-1:0] pop;
    logic [SL*IW-1:0] insn;
  } exp_t;

  exp_t sbq[$];
  int checks = 0;
  int fails  = 0;
  int m_last = NT - 1;
  bit m_hi   = 1'b0;
  logic [SL-1:0] tv [NT];
  logic [SL-1:0] tp [NT];
  logic [SL-1:0] tq [NT];

  function automatic logic [IW-1:0] mk_insn(int t, int s);
    return IW'(32'hC0DE0000 + t * 256 + s);
  endfunction

  task automatic chk(input string r, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  task automatic set_thr(int t, logic [SL-1:0] v, logic [SL-1:0] p, logic [SL-1:0] q);
    tv[t] = v; tp[t] = p; tq[t] = q;
  endtask

  function automatic int m_pick(logic [1:0] md, logic [NT-1:0] emp);
    if (&emp) return -1;
    if (md == 2'b01 || (md == 2'b10 && !m_hi)) begin
      for (int t = 0; t < NT; t++) if (!emp[t]) return t;
    end else if (md == 2'b10) begin
      for (int t = NT - 1; t >= 0; t--) if (!emp[t]) return t;
    end else begin
      for (int off = 1; off <= NT; off++) if (!emp[(m_last + off) % NT]) return (m_last + off) % NT;
    end
    return -1;
  endfunction

  function automatic int m_len(int t);
    int n = 0;
    for (int s = 0; s < SL; s++) begin
      if (!tv[t][s]) break;
      n = s + 1;
      if (tp[t][s]) break;
    end
    return n;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input logic [1:0] md, input logic [NT-1:0] emp, input string r);
    exp_t e;
    int g, n;
    @(negedge clk);
    mode_sel = md;
    q_empty  = emp;
    for (int t = 0; t < NT; t++)
      for (int s = 0; s < SL; s++) begin
        head_vld[t*SL+s]  = tv[t][s];
        head_par[t*SL+s]  = tp[t][s];
        head_pred[t*SL+s] = tq[t][s];
        head_insn[(t*SL+s)*IW +: IW] = mk_insn(t, s);
      end
    g = m_pick(md, emp);
    e.tag = r; e.gv = (g >= 0); e.tid = '0; e.sv = '0; e.pop = '0; e.insn = '0;
    if (g >= 0) begin
      n = m_len(g);
      e.tid = TW'(g);
      e.pop[g*CW +: CW] = CW'(n);
      for (int s = 0; s < n; s++) begin
        e.sv[s] = tq[g][s];
        if (tq[g][s]) e.insn[s*IW +: IW] = mk_insn(g, s);
      end
      m_last = g;
      if (md == 2'b10) m_hi = !m_hi;
    end
    sbq.push_back(e);
  endtask

  // Monitor: samples outputs between edges and compares with the queue.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbq.size() > 0) begin
        exp_t e;
        logic [SL*IW-1:0] got;
        e = sbq.pop_front();
        got = '0;
        for (int s = 0; s < SL; s++) if (e.sv[s]) got[s*IW +: IW] = issue_insn[s*IW +: IW];
        chk(e.tag, "grant_valid", 128'(grant_valid), 128'(e.gv));
        if (e.gv) chk(e.tag, "grant_tid", 128'(grant_tid), 128'(e.tid));
        chk(e.tag, "slot_valid", 128'(slot_valid), 128'(e.sv));
        chk(e.tag, "pop_cnt", 128'(pop_cnt), 128'(e.pop));
        chk(e.tag, "issue_insn", 128'(got), 128'(e.insn));
      end
    end
  end

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; q_empty = '1;
    head_vld = '0; head_par = '0; head_pred = '0; head_insn = '0;
    set_thr(0, 4'hF, 4'b0001, 4'hF);  // R8 flag on entry 0: one slot
    set_thr(1, 4'hF, 4'b0000, 4'hF);  // R9 all flags 0: capped at four
    set_thr(2, 4'hF, 4'b0100, 4'hF);  // R8 flag on entry 2: three slots
    set_thr(3, 4'b0011, 4'b0000, 4'hF); // R9 third entry absent: two slots
    set_thr(4, 4'hF, 4'b0010, 4'b0101); // R11 slot 1 predicate false
    set_thr(5, 4'hF, 4'b1000, 4'hF);  // R8 flag on entry 3: four slots
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state: idle, then rotation starts at thread 0.
    step(2'b00, 6'b111111, "R7 reset idle");
    for (int k = 0; k < 7; k++) step(2'b00, 6'b000000, "R2 R8 R9 R10 R12 rotate");
    for (int k = 0; k < 4; k++) step(2'b00, 6'b100110, "R1 skip empties");
    step(2'b00, 6'b111111, "R7 idle");
    step(2'b00, 6'b111111, "R7 idle");
    for (int k = 0; k < 3; k++) step(2'b00, 6'b000000, "R6 rotate after idle");
    step(2'b01, 6'b000000, "R3 fixed");
    step(2'b01, 6'b000001, "R3 fixed");
    step(2'b01, 6'b001011, "R3 fixed");
    step(2'b01, 6'b011111, "R3 fixed");
    step(2'b00, 6'b000000, "R6 last updated in fixed");
    for (int k = 0; k < 4; k++) step(2'b10, 6'b000000, "R4 alternate");
    step(2'b10, 6'b111111, "R6 idle alternate");
    step(2'b10, 6'b011110, "R4 R6 alternate");
    step(2'b10, 6'b011110, "R4 alternate");
    step(2'b10, 6'b101101, "R4 alternate");
    for (int k = 0; k < 4; k++) step(2'b11, 6'b010100, "R5 spare code");
    set_thr(0, 4'hF, 4'b0000, 4'b0000);
    step(2'b01, 6'b000000, "R11 all predicates false");
    set_thr(0, 4'b0001, 4'b0000, 4'b0001);
    step(2'b01, 6'b000000, "R9 single entry present");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule